// File: doc/BRIEF.md
# Subranging Converter Correction and Sequencing Logic

This block holds the digital side of a four-step subranging analog-to-digital converter. After a start pulse, a sequencer puts the sample-and-hold into hold. It then walks through four quantiser steps in a fixed order: a first 3-bit step, a second 3-bit step, a coarse 4-bit step and a fine 4-bit step. For each step it raises one strobe for a programmable number of clock cycles. On the last cycle of that strobe it captures the comparator result.

Adjacent stages share one bit of overlap, so an error in an early step is absorbed by the step that follows it. A weighted adder merges the four partial codes. It subtracts a fixed centring offset and clamps the result into a 12-bit output word with an out-of-range flag. A one-cycle done pulse marks each new result. The sample-and-hold goes back to acquire once that pulse ends.

Comparator outputs arrive as thermometer codes by default and are reduced to binary by counting ones. A parameter selects plain binary inputs instead.

Top module: `subrange_corrector`

## Requirements
- R1: After reset, hold, all four strobes, code, otr, done and busy are all 0.
- R2: A conversion raises strobe bits in the order bit 0, 1, 2, 3. At most one bit is high at a time, and each stays high for exactly STEP_CYCLES cycles (default 3), with no gap between steps.
- R3: hold goes to 1 at the clock edge that accepts start. It stays 1 through the done cycle and returns to 0 on the edge where done falls.
- R4: done is high for exactly one cycle, at the 4*STEP_CYCLES-th clock edge after the edge that accepted start. busy is 1 from the accepting edge until done rises, and 0 in the done cycle.
- R5: A start pulse while busy is 1 is ignored: conversion timing is unchanged and no extra conversion follows.
- R6: A stage's comparator input is captured only on the last cycle of its own strobe. Values on that input at other times have no effect on the result.
- R7: In thermometer mode, a stage input of width 2^B-1 is converted to a stage value equal to its number of 1 bits. A pattern with a bubble therefore gives the same value as a clean pattern with the same count.
- R8: With stage values a, b, c, d (first, second, coarse, fine), the raw sum is S = 512*a + 128*b + 16*c + d - 320. When 0 <= S <= 4095, code = S and otr = 0.
- R9: When S < 0, code = 0 and otr = 1. When S > 4095, code = 4095 and otr = 1.
- R10: code and otr change only in a cycle where done is 1, and hold their value until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, accepted when idle |
| stage1_raw | input | 7 | First 3-bit quantiser output (thermometer) |
| stage2_raw | input | 7 | Second 3-bit quantiser output (thermometer) |
| stage3_raw | input | 15 | Coarse 4-bit quantiser output (thermometer) |
| stage4_raw | input | 15 | Fine 4-bit quantiser output (thermometer) |
| hold | output | 1 | 1 = sample-and-hold in hold, 0 = acquire |
| strobe | output | 4 | One strobe per quantiser step, bit 0 first |
| code | output | 12 | Corrected conversion result |
| otr | output | 1 | Result was clamped (out of range) |
| done | output | 1 | One-cycle pulse marking a new result |
| busy | output | 1 | Conversion in progress |

## Verification
The hardest case is a corrected sum that lands just inside or just outside the 0..4095 window. The overlap offset and the limits on each stage value mean only a few combinations reach those edges. The stimulus therefore builds directed stage codes for sums of -320, 0, 4095, 4096 and the maximum, and random codes fill the middle. To show that inputs outside a strobe window are ignored, the bench drives random junk onto each stage input as soon as its strobe ends. It also fires start in the middle of a conversion to show the request is dropped.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_STEP1 = 3'd1,
        SEQ_STEP2 = 3'd2,
        SEQ_STEP3 = 3'd3,
        SEQ_STEP4 = 3'd4
    } seq_state_e;

    localparam int NUM_STEPS = 4;

endpackage

// File: rtl/stage_decode.sv
module stage_decode #(
    parameter int BITS   = 3,
    parameter bit THERMO = 1'b1,
    localparam int IN_W  = THERMO ? (2 ** BITS) - 1 : BITS
) (
    input  logic [IN_W-1:0] raw,
    output logic [BITS-1:0] value
);

    generate
        if (THERMO) begin : g_count
            always_comb begin
                logic [BITS-1:0] acc;
                acc = '0;
                for (int i = 0; i < IN_W; i++) begin
                    acc = acc + {{(BITS-1){1'b0}}, raw[i]};
                end
                value = acc;
            end
        end else begin : g_pass
            assign value = raw;
        end
    endgenerate

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import subrange_pkg::*;
#(
    parameter int STEP_CYCLES = 3,
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1,
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic [NUM_STEPS-1:0] strobe,
    output logic [NUM_STEPS-1:0] capture,
    output logic                 hold,
    output logic                 busy,
    output logic                 done
);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             hold;
        logic             done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      last_cycle;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        last_cycle = (seq_q.cnt == CNT_LAST);
        if (seq_q.done) begin
            seq_d.hold = 1'b0;
        end
        case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.state = SEQ_STEP1;
                    seq_d.cnt   = '0;
                    seq_d.hold  = 1'b1;
                end
            end
            SEQ_STEP1, SEQ_STEP2, SEQ_STEP3, SEQ_STEP4: begin
                if (last_cycle) begin
                    seq_d.cnt = '0;
                    case (seq_q.state)
                        SEQ_STEP1: seq_d.state = SEQ_STEP2;
                        SEQ_STEP2: seq_d.state = SEQ_STEP3;
                        SEQ_STEP3: seq_d.state = SEQ_STEP4;
                        default: begin
                            seq_d.state = SEQ_IDLE;
                            seq_d.done  = 1'b1;
                        end
                    endcase
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, cnt: '0, hold: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        strobe = '0;
        case (seq_q.state)
            SEQ_STEP1: strobe = 4'b0001;
            SEQ_STEP2: strobe = 4'b0010;
            SEQ_STEP3: strobe = 4'b0100;
            SEQ_STEP4: strobe = 4'b1000;
            default:   strobe = 4'b0000;
        endcase
    end

    assign capture = strobe & {NUM_STEPS{last_cycle}};
    assign hold    = seq_q.hold;
    assign busy    = (seq_q.state != SEQ_IDLE);
    assign done    = seq_q.done;

endmodule

// File: rtl/code_merger.sv
module code_merger #(
    parameter int W1    = 3,
    parameter int W2    = 3,
    parameter int W3    = 4,
    parameter int W4    = 4,
    parameter int OUT_W = 12,
    localparam int SH4  = 0,
    localparam int SH3  = W4,
    localparam int SH2  = SH3 + W3 - 1,
    localparam int SH1  = SH2 + W2 - 1,
    localparam int OFFSET = (1 << (SH1 - 1)) + (1 << (SH2 - 1)),
    localparam int SUM_W  = OUT_W + 2
) (
    input  logic [W1-1:0]    a,
    input  logic [W2-1:0]    b,
    input  logic [W3-1:0]    c,
    input  logic [W4-1:0]    d,
    output logic [OUT_W-1:0] code,
    output logic             otr
);

    localparam logic [SUM_W-1:0] MAX_CODE = SUM_W'((1 << OUT_W) - 1);

    logic [SUM_W-1:0] sum;
    logic             below, above;

    always_comb begin
        sum = (SUM_W'(a) << SH1) + (SUM_W'(b) << SH2)
            + (SUM_W'(c) << SH3) + (SUM_W'(d) << SH4)
            - SUM_W'(OFFSET);
        below = sum[SUM_W-1];
        above = !below && (sum > MAX_CODE);
        if (below) begin
            code = '0;
        end else if (above) begin
            code = '1;
        end else begin
            code = sum[OUT_W-1:0];
        end
        otr = below | above;
    end

endmodule

// File: rtl/subrange_corrector.sv
module subrange_corrector
    import subrange_pkg::*;
#(
    parameter int STEP_CYCLES = 3,
    parameter bit THERMO      = 1'b1,
    parameter int W1          = 3,
    parameter int W2          = 3,
    parameter int W3          = 4,
    parameter int W4          = 4,
    parameter int OUT_W       = 12,
    localparam int IN1 = THERMO ? (2 ** W1) - 1 : W1,
    localparam int IN2 = THERMO ? (2 ** W2) - 1 : W2,
    localparam int IN3 = THERMO ? (2 ** W3) - 1 : W3,
    localparam int IN4 = THERMO ? (2 ** W4) - 1 : W4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IN1-1:0]       stage1_raw,
    input  logic [IN2-1:0]       stage2_raw,
    input  logic [IN3-1:0]       stage3_raw,
    input  logic [IN4-1:0]       stage4_raw,
    output logic                 hold,
    output logic [NUM_STEPS-1:0] strobe,
    output logic [OUT_W-1:0]     code,
    output logic                 otr,
    output logic                 done,
    output logic                 busy
);

    typedef struct packed {
        logic [W1-1:0]    s1;
        logic [W2-1:0]    s2;
        logic [W3-1:0]    s3;
        logic [OUT_W-1:0] code;
        logic             otr;
    } core_regs_t;

    core_regs_t core_d, core_q;

    logic [NUM_STEPS-1:0] capture;
    logic [W1-1:0]        v1;
    logic [W2-1:0]        v2;
    logic [W3-1:0]        v3;
    logic [W4-1:0]        v4;
    logic [OUT_W-1:0]     merged_code;
    logic                 merged_otr;

    step_sequencer #(.STEP_CYCLES(STEP_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .strobe  (strobe),
        .capture (capture),
        .hold    (hold),
        .busy    (busy),
        .done    (done)
    );

    stage_decode #(.BITS(W1), .THERMO(THERMO)) u_dec1 (.raw(stage1_raw), .value(v1));
    stage_decode #(.BITS(W2), .THERMO(THERMO)) u_dec2 (.raw(stage2_raw), .value(v2));
    stage_decode #(.BITS(W3), .THERMO(THERMO)) u_dec3 (.raw(stage3_raw), .value(v3));
    stage_decode #(.BITS(W4), .THERMO(THERMO)) u_dec4 (.raw(stage4_raw), .value(v4));

    // The fine step feeds the adder directly on its capture cycle.
    code_merger #(
        .W1(W1), .W2(W2), .W3(W3), .W4(W4), .OUT_W(OUT_W)
    ) u_merge (
        .a    (core_q.s1),
        .b    (core_q.s2),
        .c    (core_q.s3),
        .d    (v4),
        .code (merged_code),
        .otr  (merged_otr)
    );

    always_comb begin
        core_d = core_q;
        if (capture[0]) core_d.s1 = v1;
        if (capture[1]) core_d.s2 = v2;
        if (capture[2]) core_d.s3 = v3;
        if (capture[3]) begin
            core_d.code = merged_code;
            core_d.otr  = merged_otr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign code = core_q.code;
    assign otr  = core_q.otr;

endmodule

// File: rtl/subrange_corrector_chk.sv
module subrange_corrector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  strobe,
    input logic        hold,
    input logic        busy,
    input logic        done,
    input logic [11:0] code,
    input logic        otr
);

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    // R2
    strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe[1]) |-> $past(strobe[0]));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(strobe[3]));

    // R3
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> hold);

    // R3
    hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(done));

    // R5
    begin_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe[0]) |-> $past(start) && !$past(busy));

    // R10
    code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(code) || done);

    // R9
    otr_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otr |-> (code == 12'd0) || (code == 12'd4095));

endmodule

bind subrange_corrector subrange_corrector_chk u_chk (.*);

// File: tb/subrange_corrector_bench.sv
module subrange_corrector_bench;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  stage1_raw = '0;
    logic [6:0]  stage2_raw = '0;
    logic [14:0] stage3_raw = '0;
    logic [14:0] stage4_raw = '0;
    logic        hold;
    logic [3:0]  strobe;
    logic [11:0] code;
    logic        otr;
    logic        done;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    subrange_corrector u_subrange_corrector (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stage1_raw(stage1_raw), .stage2_raw(stage2_raw),
        .stage3_raw(stage3_raw), .stage4_raw(stage4_raw),
        .hold(hold), .strobe(strobe), .code(code), .otr(otr),
        .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sum(int a, int b, int c, int d);
        return a * 512 + b * 128 + c * 16 + d - 320;
    endfunction

    function automatic int exp_code(int s);
        if (s < 0) return 0;
        if (s > 4095) return 4095;
        return s;
    endfunction

    function automatic logic [14:0] therm(int n, int w, bit bubble);
        logic [14:0] t;
        t = '0;
        for (int i = 0; i < n; i++) t[i] = 1'b1;
        if (bubble && n > 0 && n < w) begin
            t[n-1] = 1'b0;
            t[n]   = 1'b1;
        end
        return t;
    endfunction

    task automatic drive_stage(int k, logic [14:0] v);
        case (k)
            0: stage1_raw = v[6:0];
            1: stage2_raw = v[6:0];
            2: stage3_raw = v;
            default: stage4_raw = v;
        endcase
    endtask

    task automatic convert(int a, int b, int c, int d, bit bubble, bit poke);
        int vals[4];
        int widths[4];
        int cyc;
        int s;
        vals = '{a, b, c, d};
        widths = '{7, 7, 15, 15};
        s = exp_sum(a, b, c, d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        // R3
        check(hold == 1'b1 && busy == 1'b1, "R3 hold/busy at start", {hold, busy}, 3);
        for (int k = 0; k < 4; k++) begin
            int len;
            len = 0;
            check(strobe == (4'b1 << k), "R2 strobe order", strobe, 1 << k);
            while (strobe[k]) begin
                drive_stage(k, therm(vals[k], widths[k], bubble));
                if (poke && k == 1 && len == 0) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                len++;
                cyc++;
                if (k < 3) check(busy && hold, "R4 busy during conversion", {busy, hold}, 3);
            end
            // R6: junk after the window must not matter
            drive_stage(k, 15'($urandom));
            check(len == N, "R2 strobe length", len, N);
        end
        // R4 timing and pulse
        check(done == 1'b1 && cyc == 4 * N + 1, "R4 done timing", cyc, 4 * N + 1);
        check(busy == 1'b0 && hold == 1'b1, "R3 hold in done cycle", {busy, hold}, 1);
        // R8 / R9 / R7
        check(code == 12'(exp_code(s)), "R8 R9 code", code, exp_code(s));
        check(otr == ((s < 0) || (s > 4095)), "R9 otr", otr, (s < 0) || (s > 4095));
        @(negedge clk);
        check(done == 1'b0 && hold == 1'b0, "R3 hold falls with done", {done, hold}, 0);
        if (poke) begin
            repeat (2 * N) begin
                @(negedge clk);
                check(busy == 1'b0 && strobe == 4'b0, "R5 start ignored", {busy, strobe}, 0);
            end
        end
        // R10: result held while idle
        repeat (2) @(negedge clk);
        check(code == 12'(exp_code(s)), "R10 code held", code, exp_code(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check(hold == 0 && strobe == 0 && code == 0 && otr == 0 && done == 0 && busy == 0,
              "R1 reset state", {hold, strobe, code, otr, done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        convert(0, 0, 0, 0, 1'b0, 1'b0);    // R9 below range
        convert(0, 2, 4, 0, 1'b0, 1'b0);    // R8 exactly zero
        convert(7, 6, 3, 15, 1'b0, 1'b0);   // R8 exactly 4095
        convert(7, 6, 4, 0, 1'b0, 1'b0);    // R9 just above
        convert(7, 7, 15, 15, 1'b0, 1'b0);  // R9 maximum
        convert(3, 5, 9, 6, 1'b1, 1'b0);    // R7 bubble patterns
        convert(4, 1, 2, 8, 1'b0, 1'b1);    // R5 start while busy
        for (int i = 0; i < 25; i++) begin
            convert($urandom_range(7), $urandom_range(7), $urandom_range(15),
                    $urandom_range(15), 1'($urandom_range(1)), 1'($urandom_range(1)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule